// File: doc/BRIEF.md
# Pad Function and Pull Controller

This block is the register-mapped configuration unit for a bank of 54 general-purpose pins. Software reaches it through a simple 32-bit word-addressed bus. Through this bus it picks a 3-bit function code for every pin and drives the output level with separate set and clear words. It can also read the synchronized level of the pins. The block exports the function code, the output value and the output enable of every pin. A pad driver and an alternate-function router outside the block use these signals.

Pull resistors use a two-step protocol. Software first writes the wanted pull code into a control word. It then writes a strobe mask that names the pads to update. The control value must stay unchanged for a setup window before the strobe and for a hold window after it. A strobe that passes the setup check is held pending. It is applied to the masked pads only when the hold window closes without a change. Any breach of either window drops the strobe and sets a sticky error flag.

A small state machine runs the pull protocol. Its states are:
- `PS_SETTLE`: counting the setup window after the control value changed.
- `PS_READY`: setup met, no strobe pending.
- `PS_HOLD`: a strobe is pending and the hold window is being counted.

Its transitions are:
- settle-count: `PS_SETTLE` to `PS_READY`, when the count reaches its end.
- settle-restart: from `PS_SETTLE` or `PS_READY` back to `PS_SETTLE`, on a control change.
- arm: from `PS_SETTLE` (at the last setup cycle) or `PS_READY` to `PS_HOLD`, on a nonzero strobe.
- merge: `PS_HOLD` to `PS_HOLD`, when another strobe arrives.
- commit: `PS_HOLD` to `PS_READY`, when the hold count ends.
- hold-break: `PS_HOLD` to `PS_SETTLE`, on a control change.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every function code is 000, every output value and output enable is 0, every latched pull code is 0 and the timing error flag is 0.
- R2: Words 0 to 5 hold function codes. Pin n sits in word n/10 at bits (n mod 10)*3 to (n mod 10)*3+2. A write replaces the whole word. A read returns the stored codes, and bits that map to no pin read 0.
- R3: A pin's output enable is 1 exactly when its code is 001. The other codes are: input 000, alt0 100, alt1 101, alt2 110, alt3 111, alt4 011 and alt5 010. None of these enables the output.
- R4: Writing word 7 (pins 0-31, bit i is pin i) or word 8 (pins 32-53, bit i is pin 32+i) drives the pins whose bits are 1 high. Zero bits have no effect, and both words read 0.
- R5: Writing word 10 (pins 0-31) or word 11 (pins 32-53) drives the pins whose bits are 1 low. Zero bits have no effect, and both words read 0.
- R6: Word 13 returns the pin inputs 0-31 and word 14 returns pins 32-53 in bits 0-21, with bits above read 0. Both pass through a two-flop synchronizer.
- R7: Word 16 holds the pull code in bits 1:0 (0 none, 1 pull-down, 2 pull-up) and reads back what was written.
- R8: Word 17 (pins 0-31) and word 18 (pins 32-53, bits 0-21) are strobe masks. An accepted strobe written at edge S loads the current pull code into only the strobed pads, at edge S+150. All other pads keep their code, and an all-zero strobe does nothing.
- R9: A strobe is accepted only if the control word last changed value at least 150 edges earlier. A strobe 149 edges after the change is dropped and sets the error flag.
- R10: A change of the control value at edge S+1 to S+150 after an accepted strobe drops the pending update and sets the error flag. A write of the same value is not a change, and a change at S+151 is harmless.
- R11: The error flag is sticky. It reads in bit 0 of word 19 and on `pull_timing_err`, and it is cleared by writing 1 to bit 0 of word 19.
- R12: A strobe that arrives while an update is pending merges its mask into the pending one and restarts the hold window.
- R13: Reserved words (6, 9, 12, 15 and 20 to 31) read 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 when no read |
| pin_in | input | 54 | External pin levels (asynchronous) |
| pin_func | output | 162 | Function code per pin, pin n at bits 3n+2:3n |
| pin_out | output | 54 | Output value per pin |
| pin_oe | output | 54 | Output enable per pin |
| pad_pull | output | 108 | Latched pull code per pad, pad n at bits 2n+1:2n |
| pull_timing_err | output | 1 | Sticky setup/hold violation flag |

## Verification
The closing edge of a hold window and a write to the control word can land on the same clock edge. The change must win: the pending update is dropped, the pads keep their old codes and the error flag rises. The bench provokes this by writing a new pull code exactly 150 edges after a strobe. It then repeats the test one edge later, where the commit must already have happened and no error may appear. The setup side is judged the same way, with strobes placed 149 and 150 edges after a control change.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
    localparam int unsigned REG_W         = 32;
    localparam int unsigned ADDR_W        = 5;
    localparam int unsigned PINS_PER_WORD = 10;
    localparam int unsigned FCODE_W       = 3;
    localparam int unsigned PULL_W        = 2;

    typedef enum logic [FCODE_W-1:0] {
        FN_INPUT  = 3'b000,
        FN_OUTPUT = 3'b001,
        FN_ALT5   = 3'b010,
        FN_ALT4   = 3'b011,
        FN_ALT0   = 3'b100,
        FN_ALT1   = 3'b101,
        FN_ALT2   = 3'b110,
        FN_ALT3   = 3'b111
    } fn_code_e;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_code_e;

    typedef enum logic [1:0] {
        PS_SETTLE = 2'd0,
        PS_READY  = 2'd1,
        PS_HOLD   = 2'd2
    } pull_st_e;

    localparam logic [ADDR_W-1:0] A_SET_LO   = 5'd7;
    localparam logic [ADDR_W-1:0] A_SET_HI   = 5'd8;
    localparam logic [ADDR_W-1:0] A_CLR_LO   = 5'd10;
    localparam logic [ADDR_W-1:0] A_CLR_HI   = 5'd11;
    localparam logic [ADDR_W-1:0] A_LVL_LO   = 5'd13;
    localparam logic [ADDR_W-1:0] A_LVL_HI   = 5'd14;
    localparam logic [ADDR_W-1:0] A_PCTRL    = 5'd16;
    localparam logic [ADDR_W-1:0] A_PSTB_LO  = 5'd17;
    localparam logic [ADDR_W-1:0] A_PSTB_HI  = 5'd18;
    localparam logic [ADDR_W-1:0] A_PSTAT    = 5'd19;
endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
    import gpio_pad_pkg::*;
#(
    parameter int unsigned NPINS = 54
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          word_idx,
    input  logic [PINS_PER_WORD*FCODE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]          rd_idx,
    output logic [REG_W-1:0]           rd_word,
    output logic [NPINS*FCODE_W-1:0]   func_flat,
    output logic [NPINS-1:0]           oe
);
    localparam int unsigned FS_BITS = PINS_PER_WORD * FCODE_W;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int unsigned WIDX = p / PINS_PER_WORD;
        localparam int unsigned OFF  = (p % PINS_PER_WORD) * FCODE_W;
        logic [FCODE_W-1:0] fn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fn_q <= FN_INPUT;
            end else if (wr_en && (word_idx == ADDR_W'(WIDX))) begin
                fn_q <= wdata[OFF +: FCODE_W];
            end
        end

        assign func_flat[p*FCODE_W +: FCODE_W] = fn_q;
        assign oe[p] = (fn_q == FN_OUTPUT);

        // R2
        fsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (word_idx == ADDR_W'(WIDX))) |=> (fn_q == $past(wdata[OFF +: FCODE_W])));
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < int'(NPINS); p++) begin
            if (ADDR_W'(p / int'(PINS_PER_WORD)) == rd_idx) begin
                rd_word[(p % int'(PINS_PER_WORD))*FCODE_W +: FCODE_W] = func_flat[p*FCODE_W +: FCODE_W];
            end
        end
    end

    initial begin
        if (FS_BITS > REG_W) $error("function word too wide");
    end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_pad_pkg::*;
#(
    parameter int unsigned NPINS = 54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_lo_we,
    input  logic              set_hi_we,
    input  logic              clr_lo_we,
    input  logic              clr_hi_we,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  lvl_q
);
    localparam int unsigned HI_W = NPINS - REG_W;

    logic [NPINS-1:0] set_mask;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] sync1_q;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_lo_we) set_mask[REG_W-1:0]     = wdata;
        if (set_hi_we) set_mask[NPINS-1:REG_W] = wdata[HI_W-1:0];
        if (clr_lo_we) clr_mask[REG_W-1:0]     = wdata;
        if (clr_hi_we) clr_mask[NPINS-1:REG_W] = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            sync1_q <= '0;
            lvl_q   <= '0;
        end else begin
            out_q   <= (out_q | set_mask) & ~clr_mask;
            sync1_q <= pin_in;
            lvl_q   <= sync1_q;
        end
    end

    // R5
    clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi_we |=> ((out_q[NPINS-1:REG_W] & $past(wdata[HI_W-1:0])) == '0));

    // R6
    lvl_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lvl_q == $past(sync1_q)));

    initial begin
        if (NPINS <= REG_W || NPINS > 2*REG_W) $error("pin count out of range");
    end
endmodule

// File: rtl/gpio_pull_seq.sv
module gpio_pull_seq
    import gpio_pad_pkg::*;
#(
    parameter int unsigned NPINS     = 54,
    parameter int unsigned SETUP_CYC = 150,
    parameter int unsigned HOLD_CYC  = 150
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_we,
    input  logic                      stb_lo_we,
    input  logic                      stb_hi_we,
    input  logic                      stat_we,
    input  logic [REG_W-1:0]          wdata,
    output logic [PULL_W-1:0]         ctrl_q,
    output logic [NPINS*PULL_W-1:0]   pull_flat,
    output logic                      err_q
);
    localparam int unsigned HI_W  = NPINS - REG_W;
    localparam int unsigned MAXC  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    pull_st_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [NPINS-1:0]  mask_q, mask_d;
    logic [NPINS-1:0]  stb_mask;
    logic              stb_any;
    logic              ctrl_chg;
    logic              commit;
    logic              viol;

    assign ctrl_chg = ctrl_we && (wdata[PULL_W-1:0] != ctrl_q);

    always_comb begin
        stb_mask = '0;
        if (stb_lo_we) stb_mask[REG_W-1:0]     = wdata;
        if (stb_hi_we) stb_mask[NPINS-1:REG_W] = wdata[HI_W-1:0];
    end
    assign stb_any = |stb_mask;

    // next state and counters
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        mask_d = mask_q;
        commit = 1'b0;
        viol   = 1'b0;
        unique case (st_q)
            PS_SETTLE: begin
                if (ctrl_chg) begin
                    cnt_d = '0;
                end else if (stb_any && (cnt_q == SETUP_LAST)) begin
                    st_d   = PS_HOLD;
                    cnt_d  = '0;
                    mask_d = stb_mask;
                end else begin
                    viol = stb_any;
                    if (cnt_q == SETUP_LAST) begin
                        st_d = PS_READY;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PS_READY: begin
                if (ctrl_chg) begin
                    st_d  = PS_SETTLE;
                    cnt_d = '0;
                end else if (stb_any) begin
                    st_d   = PS_HOLD;
                    cnt_d  = '0;
                    mask_d = stb_mask;
                end
            end
            PS_HOLD: begin
                if (ctrl_chg) begin
                    viol   = 1'b1;
                    st_d   = PS_SETTLE;
                    cnt_d  = '0;
                    mask_d = '0;
                end else if (stb_any) begin
                    cnt_d  = '0;
                    mask_d = mask_q | stb_mask;
                end else if (cnt_q == HOLD_LAST) begin
                    commit = 1'b1;
                    st_d   = PS_READY;
                    cnt_d  = '0;
                    mask_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = PS_SETTLE;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_SETTLE;
            cnt_q  <= '0;
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            mask_q <= mask_d;
        end
    end

    // outputs: control word, pad codes, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= PULL_NONE;
            pull_flat <= '0;
            err_q     <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata[PULL_W-1:0];
            if (commit) begin
                for (int p = 0; p < int'(NPINS); p++) begin
                    if (mask_q[p]) pull_flat[p*PULL_W +: PULL_W] <= ctrl_q;
                end
            end
            if (viol) begin
                err_q <= 1'b1;
            end else if (stat_we && wdata[0]) begin
                err_q <= 1'b0;
            end
        end
    end

    // R8
    pull_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_flat) |-> ($past(st_q) == PS_HOLD));

    // R10
    hold_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_HOLD && ctrl_chg) |=> (err_q && st_q == PS_SETTLE && $stable(pull_flat)));

    // R9
    early_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SETTLE && !ctrl_chg && stb_any && cnt_q != SETUP_LAST) |=> (err_q && st_q != PS_HOLD));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(stat_we && wdata[0])) |=> err_q);

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(ctrl_we || stb_lo_we || stb_hi_we));

    initial begin
        if (SETUP_CYC < 1 || HOLD_CYC < 1) $error("window lengths must be at least 1");
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int unsigned NPINS     = 54,
    parameter int unsigned SETUP_CYC = 150,
    parameter int unsigned HOLD_CYC  = 150
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [4:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NPINS-1:0]          pin_in,
    output logic [NPINS*3-1:0]        pin_func,
    output logic [NPINS-1:0]          pin_out,
    output logic [NPINS-1:0]          pin_oe,
    output logic [NPINS*2-1:0]        pad_pull,
    output logic                      pull_timing_err
);
    localparam int unsigned FSEL_WORDS = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam int unsigned FS_BITS    = PINS_PER_WORD * FCODE_W;

    logic               fsel_hit;
    logic [REG_W-1:0]   fsel_rd;
    logic [NPINS-1:0]   lvl;
    logic [PULL_W-1:0]  pctrl;
    logic [REG_W-1:0]   rd_d;

    assign fsel_hit = (bus_addr < ADDR_W'(FSEL_WORDS));

    gpio_fsel_bank #(.NPINS(NPINS)) u_fsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && fsel_hit),
        .word_idx (bus_addr),
        .wdata    (bus_wdata[FS_BITS-1:0]),
        .rd_idx   (bus_addr),
        .rd_word  (fsel_rd),
        .func_flat(pin_func),
        .oe       (pin_oe)
    );

    gpio_out_bank #(.NPINS(NPINS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lo_we(bus_wr && bus_addr == A_SET_LO),
        .set_hi_we(bus_wr && bus_addr == A_SET_HI),
        .clr_lo_we(bus_wr && bus_addr == A_CLR_LO),
        .clr_hi_we(bus_wr && bus_addr == A_CLR_HI),
        .wdata    (bus_wdata),
        .pin_in   (pin_in),
        .out_q    (pin_out),
        .lvl_q    (lvl)
    );

    gpio_pull_seq #(.NPINS(NPINS), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_pull (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (bus_wr && bus_addr == A_PCTRL),
        .stb_lo_we(bus_wr && bus_addr == A_PSTB_LO),
        .stb_hi_we(bus_wr && bus_addr == A_PSTB_HI),
        .stat_we  (bus_wr && bus_addr == A_PSTAT),
        .wdata    (bus_wdata),
        .ctrl_q   (pctrl),
        .pull_flat(pad_pull),
        .err_q    (pull_timing_err)
    );

    always_comb begin
        rd_d = '0;
        if (fsel_hit) begin
            rd_d = fsel_rd;
        end else begin
            unique case (bus_addr)
                A_LVL_LO: rd_d = lvl[REG_W-1:0];
                A_LVL_HI: rd_d = REG_W'(lvl[NPINS-1:REG_W]);
                A_PCTRL:  rd_d = REG_W'(pctrl);
                A_PSTAT:  rd_d = REG_W'(pull_timing_err);
                default:  rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_d : '0;
        end
    end

    // R4
    set_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET_LO) |=> ((pin_out[REG_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R5
    clr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR_LO) |=> ((pin_out[REG_W-1:0] & $past(bus_wdata)) == '0));

    // R4
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_SET_LO || bus_addr == A_SET_HI ||
                    bus_addr == A_CLR_LO || bus_addr == A_CLR_HI)) |=> (bus_rdata == '0));

    // R13
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 5'd6 || bus_addr == 5'd9 || bus_addr == 5'd12 ||
                    bus_addr == 5'd15 || bus_addr > A_PSTAT))
        |=> ($stable(pin_func) && $stable(pin_out) && $stable(pad_pull)));
endmodule

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
    localparam int NP = 54;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP*3-1:0] pin_func;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [NP*2-1:0] pad_pull;
    logic            pull_timing_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [NP*3-1:0] m_fn   = '0;
    logic [NP-1:0]   m_out  = '0;
    logic [NP*2-1:0] m_pull = '0;

    always #2.5 clk = ~clk;

    gpio_pad_ctrl u_gpio_pad_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_func(pin_func), .pin_out(pin_out), .pin_oe(pin_oe),
        .pad_pull(pad_pull), .pull_timing_err(pull_timing_err)
    );

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] exp_oe(input logic [NP*3-1:0] f);
        logic [NP-1:0] r = '0;
        for (int p = 0; p < NP; p++) r[p] = (f[p*3 +: 3] == 3'b001);
        return r;
    endfunction

    function automatic logic [31:0] exp_fword(input logic [NP*3-1:0] f, input int w);
        logic [31:0] r = '0;
        for (int p = 0; p < NP; p++)
            if (p / 10 == w) r[(p % 10)*3 +: 3] = f[p*3 +: 3];
        return r;
    endfunction

    task automatic wr_fsel(input int w, input logic [31:0] d);
        wr(5'(w), d);
        for (int p = 0; p < NP; p++)
            if (p / 10 == w) m_fn[p*3 +: 3] = d[(p % 10)*3 +: 3];
    endtask

    task automatic set_pull(input int p, input logic [1:0] v);
        m_pull[p*2 +: 2] = v;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int unsigned seed_v;
        seed_v = $urandom(32'd1234);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 func", 192'(pin_func), '0);
        chk("R1 out", 192'(pin_out), '0);
        chk("R1 oe", 192'(pin_oe), '0);
        chk("R1 pull", 192'(pad_pull), '0);
        chk("R1 err", 192'(pull_timing_err), '0);

        // R2 R3 random function words
        for (int i = 0; i < 24; i++) begin
            int w;
            logic [31:0] d;
            w = int'($urandom % 6);
            d = $urandom;
            wr_fsel(w, d);
            chk("R2 func", 192'(pin_func), 192'(m_fn));
            chk("R3 oe", 192'(pin_oe), 192'(exp_oe(m_fn)));
            w = int'($urandom % 6);
            rd(5'(w), rv);
            chk("R2 readback", 192'(rv), 192'(exp_fword(m_fn, w)));
        end

        // R3 alt4 / alt5 / output directed
        wr_fsel(1, {23'd0, 3'b001, 3'b010, 3'b011});
        chk("R3 alt4 oe", 192'(pin_oe[10]), 192'(1'b0));
        chk("R3 alt5 oe", 192'(pin_oe[11]), 192'(1'b0));
        chk("R3 output oe", 192'(pin_oe[12]), 192'(1'b1));
        chk("R3 codes", 192'(pin_func[38:30]), 192'(9'b001_010_011));

        // R4 R5 random set / clear
        for (int i = 0; i < 32; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 4);
            d  = $urandom;
            case (op)
                0: begin wr(5'd7,  d); m_out[31:0]  = m_out[31:0] | d; end
                1: begin wr(5'd8,  d); m_out[53:32] = m_out[53:32] | d[21:0]; end
                2: begin wr(5'd10, d); m_out[31:0]  = m_out[31:0] & ~d; end
                default: begin wr(5'd11, d); m_out[53:32] = m_out[53:32] & ~d[21:0]; end
            endcase
            chk(op < 2 ? "R4 set" : "R5 clear", 192'(pin_out), 192'(m_out));
        end
        wr(5'd7, 32'h0); chk("R4 zero write", 192'(pin_out), 192'(m_out));
        wr(5'd10, 32'h0); chk("R5 zero write", 192'(pin_out), 192'(m_out));
        rd(5'd7, rv);  chk("R4 read lo", 192'(rv), '0);
        rd(5'd8, rv);  chk("R4 read hi", 192'(rv), '0);
        rd(5'd10, rv); chk("R5 read lo", 192'(rv), '0);
        rd(5'd11, rv); chk("R5 read hi", 192'(rv), '0);

        // R6 levels
        for (int i = 0; i < 6; i++) begin
            logic [63:0] pv;
            pv = {$urandom, $urandom};
            pin_in = pv[NP-1:0];
            idle(3);
            rd(5'd13, rv); chk("R6 level lo", 192'(rv), 192'(pv[31:0]));
            rd(5'd14, rv); chk("R6 level hi", 192'(rv), 192'({10'd0, pv[53:32]}));
        end

        // R13 reserved words
        for (int i = 0; i < 8; i++) begin
            logic [4:0] a;
            a = (i < 4) ? 5'(6 + 3*i) : 5'(20 + $urandom % 12);
            wr(a, $urandom);
            chk("R13 no effect", 192'({pin_func, pin_out}), 192'({m_fn, m_out}));
            chk("R13 pull", 192'(pad_pull), 192'(m_pull));
            rd(a, rv); chk("R13 read", 192'(rv), '0);
        end

        // R7 control readback
        wr(5'd16, 32'd2); rd(5'd16, rv); chk("R7 ctrl up", 192'(rv), 192'(2));
        wr(5'd16, 32'd1); rd(5'd16, rv); chk("R7 ctrl down", 192'(rv), 192'(1));

        // R9 strobe one edge early
        wr(5'd16, 32'd2);
        idle(148);
        wr(5'd17, 32'h0000_0008);
        chk("R9 early err", 192'(pull_timing_err), 192'(1'b1));
        idle(160);
        chk("R9 early ignored", 192'(pad_pull), 192'(m_pull));
        chk("R11 sticky", 192'(pull_timing_err), 192'(1'b1));
        rd(5'd19, rv); chk("R11 status read", 192'(rv), 192'(1));
        wr(5'd19, 32'd0); chk("R11 zero keeps", 192'(pull_timing_err), 192'(1'b1));
        wr(5'd19, 32'd1); chk("R11 clear", 192'(pull_timing_err), 192'(1'b0));

        // R8 R9 R12 strobe exactly at setup boundary, merged second strobe
        wr(5'd16, 32'd1);
        idle(149);
        wr(5'd17, 32'h0000_0028);
        wr(5'd18, 32'h0000_0001);
        idle(149);
        chk("R12 restart hold", 192'(pad_pull), 192'(m_pull));
        idle(1);
        set_pull(3, 2'd1); set_pull(5, 2'd1); set_pull(32, 2'd1);
        chk("R8 commit", 192'(pad_pull), 192'(m_pull));
        chk("R9 boundary no err", 192'(pull_timing_err), 192'(1'b0));

        // R8 zero strobe does nothing
        wr(5'd17, 32'h0); idle(200);
        chk("R8 zero strobe", 192'(pad_pull), 192'(m_pull));

        // R10 change on last hold edge
        wr(5'd16, 32'd2);
        idle(149);
        wr(5'd18, 32'h0000_0100);
        idle(149);
        wr(5'd16, 32'd0);
        chk("R10 last edge err", 192'(pull_timing_err), 192'(1'b1));
        idle(200);
        chk("R10 dropped", 192'(pad_pull), 192'(m_pull));
        wr(5'd19, 32'd1);

        // R10 same-value write during hold is harmless
        idle(160);
        wr(5'd17, 32'h0000_0008);
        idle(50);
        wr(5'd16, 32'd0);
        idle(99);
        set_pull(3, 2'd0);
        chk("R10 same value", 192'(pad_pull), 192'(m_pull));
        chk("R10 same value err", 192'(pull_timing_err), 192'(1'b0));

        // R10 change one edge after the window
        wr(5'd16, 32'd2);
        idle(149);
        wr(5'd17, 32'h0000_0020);
        idle(150);
        wr(5'd16, 32'd1);
        set_pull(5, 2'd2);
        chk("R10 after window", 192'(pad_pull), 192'(m_pull));
        chk("R10 after window err", 192'(pull_timing_err), 192'(1'b0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule